// File: doc/BRIEF.md
# Two-Stage Fractional Pixel Clock Divider

This block turns one of several source tick streams into a pixel strobe, so that a display pipeline running on a single fast system clock can advance one pixel per strobe. Each source is given as a one-cycle enable pulse on the system clock. A select value picks the source. A first stage divides the selected ticks by 1 or by a half-integer ratio from 1.5 to 6.5. A second stage divides the result by an 8-bit integer. The overall ratio is the product of the two stage ratios.

A half-integer ratio n+0.5 is made by alternating first-stage periods of n and n+1 ticks, starting with the short one. Every pair of periods therefore spans 2n+1 ticks. A second divisor of zero switches the strobe off. Settings written while the divider runs are held in a shadow register and adopted only at a first-stage boundary. At that point both stages restart, so no shortened or stretched period reaches the output.

The first stage is a small state machine with three states. IDLE holds the counter at zero while the block is disabled. SHORT counts a period of n ticks, or of 1 tick for an integer ratio. LONG counts a period of n+1 ticks. Its transitions are:
- start: IDLE to SHORT, one cycle after enable rises.
- lengthen: SHORT to LONG at a boundary, when the ratio is half-integer and no restart is pending.
- shorten: LONG to SHORT at any boundary.
- restart: any running state goes to SHORT at a boundary where new settings are adopted.
- stop: any state goes to IDLE when enable is low.
- repeat: SHORT stays in SHORT at a boundary for an integer ratio.

Top module: `pixclk_frac_div`

## Requirements
- R1: The source select value s (0 to 3) makes `src_tick[s]` the only tick input that counts; pulses on the other three inputs have no effect on the output.
- R2: First-divisor code 0, and the reserved code 7, give ratio 1: every counted tick ends a first-stage period.
- R3: First-divisor code n (1 to 6) gives ratio n+0.5. First-stage periods alternate n and n+1 counted ticks, and the first period after a start or restart is n ticks.
- R4: A second divisor N (1 to 255) produces one pixel strobe for every N first-stage periods, on the Nth. The total ratio is therefore the first-stage ratio times N.
- R5: `pix_stb` is high for exactly the one cycle that follows the cycle holding the counted tick that completes the strobe's period.
- R6: While the active second divisor is 0, `pix_stb` stays low and `pix_off` is high.
- R7: While `enable` is low, ticks are not counted and both counters hold at zero. `pix_stb` stays low, and `pix_off` is high from the cycle after `enable` falls. Ticks are also ignored in the cycle in which `enable` rises.
- R8: Changes to select, first-divisor code or second divisor made while running take effect only at the next first-stage boundary. That boundary and its strobe decision still use the old settings. After it, both counters and the half-integer pattern restart.
- R9: During reset `pix_stb` is low and `pix_off` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global run enable |
| src_tick | input | 4 | One-cycle tick strobes of the four sources |
| src_sel | input | 2 | Source select |
| fd_code | input | 3 | First-stage ratio code |
| sd_div | input | 8 | Second-stage divisor, 0 switches off |
| pix_stb | output | 1 | One-cycle pixel strobe |
| pix_off | output | 1 | High while the strobe is disabled |

## Verification
A per-cycle reference model predicts the strobe and the off flag, and it is stressed by settings changed in the middle of a period. A divider that adopted new settings at once would, in that case, emit a strobe after too few or too many ticks, or would carry a stale second-stage count past a smaller divisor. Half-integer codes are checked against tick counts that are multiples of 2n+1, which exposes a pattern that starts with the long period or never alternates. Further targets are the unselected sources, the ignored tick in the enable-rising cycle, the reserved code 7 and a divisor of zero. Any of these decoded wrongly shows up as extra or missing strobes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int FD_W = 3;
    localparam int C1_W = 3;

    typedef enum logic [1:0] {
        F1_IDLE  = 2'd0,
        F1_SHORT = 2'd1,
        F1_LONG  = 2'd2
    } f1_state_e;

    // integer part of the first-stage ratio; codes 0 and 7 mean ratio 1
    function automatic logic [C1_W-1:0] fd_base(input logic [FD_W-1:0] code);
        if (code == 3'd0 || code == 3'd7) fd_base = 3'd1;
        else                              fd_base = code;
    endfunction

    function automatic logic fd_is_half(input logic [FD_W-1:0] code);
        fd_is_half = (code != 3'd0) && (code != 3'd7);
    endfunction

endpackage

// File: rtl/pcd_cfg_shadow.sv
module pcd_cfg_shadow #(
    parameter int SEL_W = 2,
    parameter int FD_W  = 3,
    parameter int SD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             boundary,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [FD_W-1:0]  fd_in,
    input  logic [SD_W-1:0]  sd_in,
    output logic [SEL_W-1:0] sel_q,
    output logic [FD_W-1:0]  fd_q,
    output logic [SD_W-1:0]  sd_q,
    output logic             changed
);

    logic load;

    always_comb begin
        changed = (sel_in != sel_q) || (fd_in != fd_q) || (sd_in != sd_q);
        // follow the inputs freely while stopped, otherwise only at a boundary
        load    = !enable || (boundary && changed);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            fd_q  <= '0;
            sd_q  <= '0;
        end else if (load) begin
            sel_q <= sel_in;
            fd_q  <= fd_in;
            sd_q  <= sd_in;
        end
    end

    assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !$past(boundary)) |-> ($stable(sel_q) && $stable(fd_q) && $stable(sd_q)));

endmodule

// File: rtl/pcd_frac_stage.sv
module pcd_frac_stage
    import pcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            tick,
    input  logic [FD_W-1:0] fd_code,
    input  logic            restart,
    output logic            boundary,
    output logic            running
);

    f1_state_e       state_q, state_d;
    logic [C1_W-1:0] cnt_q, cnt_d;
    logic [C1_W-1:0] base;
    logic [C1_W-1:0] last;
    logic            half;

    // outputs of the state machine
    always_comb begin
        base     = fd_base(fd_code);
        half     = fd_is_half(fd_code);
        last     = (state_q == F1_LONG) ? base : base - 1'b1;
        running  = (state_q != F1_IDLE);
        boundary = enable && tick && running && (cnt_q == last);
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = F1_IDLE;
        end else begin
            unique case (state_q)
                F1_IDLE:  state_d = F1_SHORT;
                F1_SHORT: if (boundary && !restart && half) state_d = F1_LONG;
                F1_LONG:  if (boundary) state_d = F1_SHORT;
                default:  state_d = F1_IDLE;
            endcase
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (!enable || !running) cnt_d = '0;
        else if (boundary)       cnt_d = '0;
        else if (tick)           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= F1_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F1_IDLE) |-> (cnt_q == '0));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q <= base));

    assert_long_only_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F1_LONG) |-> half);

endmodule

// File: rtl/pcd_int_stage.sv
module pcd_int_stage #(
    parameter int SD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            f1_pulse,
    input  logic            restart,
    input  logic [SD_W-1:0] sd_div,
    output logic            pix_stb
);

    logic [SD_W-1:0] cnt_q;
    logic            off;
    logic            hit;

    always_comb begin
        off = (sd_div == '0);
        hit = !off && (cnt_q == sd_div - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pix_stb <= 1'b0;
        end else begin
            pix_stb <= enable && f1_pulse && hit;
            if (!enable || off)         cnt_q <= '0;
            else if (f1_pulse) begin
                if (restart || hit)     cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_cnt_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_div != '0) |-> (cnt_q < sd_div));

    assert_cnt_zero_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_div == '0) |-> (cnt_q == '0));

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_div == '0) && ($past(sd_div) == '0)) |-> !pix_stb);

    assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !pix_stb);

endmodule

// File: rtl/pixclk_frac_div.sv
module pixclk_frac_div
    import pcd_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SD_W    = 8,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [FD_W-1:0]    fd_code,
    input  logic [SD_W-1:0]    sd_div,
    output logic               pix_stb,
    output logic               pix_off
);

    logic [SEL_W-1:0] sel_q;
    logic [FD_W-1:0]  fd_q;
    logic [SD_W-1:0]  sd_q;
    logic             changed;
    logic             boundary;
    logic             running;
    logic             restart;
    logic             tick;

    always_comb begin
        tick    = src_tick[sel_q];
        restart = boundary && changed;
        pix_off = !running || (sd_q == '0);
    end

    pcd_cfg_shadow #(
        .SEL_W (SEL_W),
        .FD_W  (FD_W),
        .SD_W  (SD_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .boundary (boundary),
        .sel_in   (src_sel),
        .fd_in    (fd_code),
        .sd_in    (sd_div),
        .sel_q    (sel_q),
        .fd_q     (fd_q),
        .sd_q     (sd_q),
        .changed  (changed)
    );

    pcd_frac_stage u_frac (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick     (tick),
        .fd_code  (fd_q),
        .restart  (restart),
        .boundary (boundary),
        .running  (running)
    );

    pcd_int_stage #(
        .SD_W (SD_W)
    ) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .f1_pulse (boundary),
        .restart  (restart),
        .sd_div   (sd_q),
        .pix_stb  (pix_stb)
    );

    assert_reset_outputs_R9: assert property (@(posedge clk)
        !rst_n |-> (!pix_stb && pix_off));

endmodule

// File: tb/pixclk_frac_div_tb.sv
module pixclk_frac_div_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] src_tick = 4'd0;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] fd_code = 3'd0;
    logic [7:0] sd_div = 8'd0;
    logic       pix_stb;
    logic       pix_off;

    int n_cmp = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    string cur_req = "R9";

    logic [1:0] exp_q[$];

    always #5 clk = ~clk;

    pixclk_frac_div u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .src_tick (src_tick),
        .src_sel  (src_sel),
        .fd_code  (fd_code),
        .sd_div   (sd_div),
        .pix_stb  (pix_stb),
        .pix_off  (pix_off)
    );

    // reference model built from the requirements
    int         m_acc = 1;
    int         m_c2 = 0;
    logic       m_run = 1'b0;
    logic [1:0] m_sel = '0;
    logic [2:0] m_fd = '0;
    logic [7:0] m_sd = '0;

    always @(posedge clk) begin
        logic bnd, est;
        int   dd;
        bnd = 1'b0;
        est = 1'b0;
        if (!rst_n) begin
            m_acc = 1; m_c2 = 0; m_run = 1'b0;
            m_sel = '0; m_fd = '0; m_sd = '0;
            exp_q.push_back(2'b01);
        end else begin
            if (m_run && enable && src_tick[m_sel]) begin
                dd = (m_fd == 3'd0 || m_fd == 3'd7) ? 2 : 2 * int'(m_fd) + 1;
                m_acc += 2;
                if (m_acc >= dd) begin
                    bnd = 1'b1;
                    m_acc -= dd;
                end
            end
            if (bnd) begin
                est = (m_sd != 0) && (m_c2 == int'(m_sd) - 1);
                if (m_sd == 0 || est) m_c2 = 0;
                else                  m_c2 = m_c2 + 1;
            end
            if (!enable || (bnd && (src_sel != m_sel || fd_code != m_fd || sd_div != m_sd))) begin
                m_sel = src_sel; m_fd = fd_code; m_sd = sd_div;
                m_acc = 1; m_c2 = 0;
            end
            m_run = enable;
            exp_q.push_back({est, !m_run || (m_sd == 0)});
        end
    end

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            e = exp_q.pop_front();
            n_cmp++;
            if ({pix_stb, pix_off} !== e) begin
                n_bad++;
                $display("FAIL %s: {pix_stb,pix_off} = %b, expected %b at %0t",
                         cur_req, {pix_stb, pix_off}, e, $time);
            end
            if (pix_stb === 1'b1) stb_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] s, input logic [2:0] f, input logic [7:0] d);
        enable = 1'b0;
        src_tick = 4'd0;
        src_sel = s; fd_code = f; sd_div = d;
        cyc(2);
        enable = 1'b1;
        cyc(2);
        stb_cnt = 0;
    endtask

    task automatic burst(input logic [3:0] pat, input int n);
        src_tick = pat;
        cyc(n);
        src_tick = 4'd0;
        cyc(3);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R9: reset state
        cyc(3);
        @(negedge clk);
        check("R9 pix_stb", int'(pix_stb), 0);
        check("R9 pix_off", int'(pix_off), 1);
        @(posedge clk); #2;
        rst_n = 1'b1;
        cyc(2);

        // R2: ratio 1 for code 0 and reserved code 7
        cur_req = "R2";
        setup(2'd0, 3'd0, 8'd1);
        burst(4'b0001, 20);
        check("R2 code0 strobes", stb_cnt, 20);
        setup(2'd0, 3'd7, 8'd4);
        burst(4'b0001, 20);
        check("R2 code7 strobes", stb_cnt, 5);

        // R3: half-integer ratios
        cur_req = "R3";
        setup(2'd0, 3'd3, 8'd1);
        burst(4'b0001, 70);
        check("R3 ratio 3.5 strobes", stb_cnt, 20);
        setup(2'd0, 3'd1, 8'd1);
        burst(4'b0001, 9);
        check("R3 ratio 1.5 strobes", stb_cnt, 6);
        setup(2'd0, 3'd6, 8'd1);
        burst(4'b0001, 6);
        check("R3 first period short", stb_cnt, 1);

        // R4: cascade product 2.5 * 3
        cur_req = "R4";
        setup(2'd0, 3'd2, 8'd3);
        burst(4'b0001, 150);
        check("R4 ratio 7.5 strobes", stb_cnt, 20);

        // R1: only the selected source counts
        cur_req = "R1";
        setup(2'd2, 3'd0, 8'd2);
        burst(4'b1011, 30);
        check("R1 unselected ignored", stb_cnt, 0);
        for (int i = 0; i < 20; i++) begin
            src_tick = 4'b0100; cyc(1);
            src_tick = 4'b1011; cyc(1);
        end
        burst(4'b0000, 1);
        check("R1 selected sparse", stb_cnt, 10);

        // R5: single-cycle latency
        cur_req = "R5";
        setup(2'd0, 3'd0, 8'd1);
        src_tick = 4'b0001;
        cyc(1);
        src_tick = 4'b0000;
        @(negedge clk);
        check("R5 strobe next cycle", int'(pix_stb), 1);
        @(negedge clk);
        check("R5 strobe one cycle", int'(pix_stb), 0);
        @(posedge clk); #2;

        // R6: divisor 0 switches off
        cur_req = "R6";
        setup(2'd0, 3'd0, 8'd0);
        @(negedge clk);
        check("R6 off flag", int'(pix_off), 1);
        @(posedge clk); #2;
        burst(4'b0001, 30);
        check("R6 no strobes", stb_cnt, 0);

        // R7: disable holds, re-enable ignores the first tick
        cur_req = "R7";
        setup(2'd0, 3'd0, 8'd1);
        enable = 1'b0;
        src_tick = 4'b0001;
        cyc(1);
        @(negedge clk);
        check("R7 off flag when disabled", int'(pix_off), 1);
        @(posedge clk); #2;
        cyc(9);
        check("R7 no strobes when disabled", stb_cnt, 0);
        enable = 1'b1;
        burst(4'b0001, 5);
        check("R7 first enabled tick ignored", stb_cnt, 4);

        // R8: changes deferred to the first-stage boundary
        cur_req = "R8";
        setup(2'd0, 3'd0, 8'd5);
        burst(4'b0001, 3);
        sd_div = 8'd2;
        cyc(3);
        @(negedge clk);
        check("R8 off flag unchanged", int'(pix_off), 0);
        @(posedge clk); #2;
        burst(4'b0001, 3);
        check("R8 deferred divisor", stb_cnt, 1);

        // R8: random changes in flight, scoreboard checks each cycle
        for (int i = 0; i < 4000; i++) begin
            src_tick = 4'($urandom);
            if ($urandom_range(99) < 4) enable = ~enable;
            if ($urandom_range(99) < 3) begin
                src_sel = 2'($urandom);
                fd_code = 3'($urandom);
                sd_div  = ($urandom_range(9) == 0) ? 8'd255 : 8'($urandom_range(5));
            end
            cyc(1);
        end
        src_tick = 4'd0;
        cyc(3);

        finish_run();
    end

endmodule